// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This controller collects up to 26 request lines from peripherals and external pins, holds each in a pending flag and offers one winning vector to a CPU over a simple vector/acknowledge/return handshake. Vector 0 is the reset entry and vector 1 is the trap. Both are non-maskable. Every other vector carries a two-bit level that software writes through a small register port. Code 0 disables the vector and codes 1 to 3 are increasing priorities.

The controller tracks the level of the handler that is running. It keeps a stack of the levels that were interrupted, so that handlers nest: a request only interrupts the CPU when its level is strictly above the running one. When a handler returns, the interrupted level comes back. A global mask silences every maskable vector. A combinational wake output lets the external-pin vectors rouse the system while its clock is stopped.

Top module: `intc_core`

## Requirements
- R1: After reset every maskable level reads 0, the global mask is clear, the running level is 0, and only vector 0 is pending. So `irq_o`=1 with `vec_o`=0.
- R2: A write with `cfg_addr_i` in 2..25 stores `cfg_wdata_i` as that vector's level. Address 31 stores bit 0 as the global mask. Writes to addresses 0 and 1 are ignored and those addresses read 0. `cfg_rdata_o` returns the stored value for the addressed location.
- R3: A high `req_i` bit in a cycle sets that vector's pending flag from the next cycle on. Accepting that vector clears the flag. A request in the same cycle as its acceptance leaves the flag set.
- R4: A pending vector is eligible if it is vector 0 or 1, or if its level is non-zero and the mask is clear. The winner has the highest effective level: reset 5, trap 4, otherwise the level written. Ties go to the lowest vector index.
- R5: `irq_o` is high only when the winner's effective level is strictly above `cur_lvl_o`. A request at an equal level waits.
- R6: `ack_i` while `irq_o` is high accepts `vec_o`: the running level is saved and `cur_lvl_o` becomes the winner's level. `ack_i` while `irq_o` is low has no effect.
- R7: `ret_i` restores the most recently saved level. `ret_i` with nothing saved leaves `cur_lvl_o` at 0.
- R8: Levels 1, 2, 3 and the trap (4) nest four deep and unwind in reverse order.
- R9: Accepting vector 0 sets `cur_lvl_o` to 0 and discards all saved levels.
- R10: The global mask blocks vectors 2..25 but never vectors 0 and 1.
- R11: `wake_o` is high, without any clock edge, while `halt_i` is high and any of vectors 2..7 has `req_i` high and a non-zero level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 26 | Request per vector |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 5 | Configuration address (vector index, 31 = mask) |
| cfg_wdata_i | input | 2 | Configuration write data |
| cfg_rdata_o | output | 2 | Configuration read data |
| irq_o | output | 1 | Interrupt request to CPU |
| vec_o | output | 5 | Winning vector index |
| ack_i | input | 1 | CPU accepts `vec_o` |
| ret_i | input | 1 | CPU leaves current handler |
| cur_lvl_o | output | 3 | Running level (0 idle, 1-3 maskable, 4 trap) |
| halt_i | input | 1 | System clock is stopped |
| wake_o | output | 1 | Wake indication from external vectors |

## Verification
The assertions assume that the CPU raises `ack_i` and `ret_i` as single-cycle pulses, never in the same cycle, and only issues `ret_i` while a handler is running. They also assume that levels change only between handlers. The stimulus drives every input on the falling edge. It pulses acknowledge and return one at a time, and it reconfigures levels and the mask only at running level 0. Whenever it interrupts a handler, it returns from that handler before starting the next scenario.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned RUN_W      = 3;
  localparam int unsigned SW_W       = 2;
  localparam int unsigned FIXED_VECS = 2;
  localparam int unsigned RST_VEC    = 0;
  localparam int unsigned TRAP_VEC   = 1;

  typedef logic [RUN_W-1:0] run_lvl_t;
  typedef logic [SW_W-1:0]  sw_lvl_t;

  localparam run_lvl_t LVL_IDLE  = 3'd0;
  localparam run_lvl_t LVL_TRAP  = 3'd4;
  localparam run_lvl_t LVL_RESET = 3'd5;
endpackage

// File: rtl/intc_cfg.sv
module intc_cfg
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 26,
  parameter int unsigned IDX_W   = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we_i,
  input  logic [IDX_W-1:0]              addr_i,
  input  sw_lvl_t                       wdata_i,
  output sw_lvl_t                       rdata_o,
  output logic [NUM_VEC-1:0][SW_W-1:0]  sw_lvl_o,
  output logic                          gmask_o
);
  localparam logic [IDX_W-1:0] MASK_ADDR = '1;

  // Per-vector level registers; fixed entries carry no storage
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_lvl
    if (i < FIXED_VECS) begin : g_fixed
      assign sw_lvl_o[i] = '0;
    end else begin : g_reg
      sw_lvl_t lvl_d, lvl_q;
      always_comb begin
        lvl_d = lvl_q;
        if (we_i && (addr_i == IDX_W'(i))) lvl_d = wdata_i;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
      end
      assign sw_lvl_o[i] = lvl_q;
    end
  end

  logic mask_d, mask_q;
  always_comb begin
    mask_d = mask_q;
    if (we_i && (addr_i == MASK_ADDR)) mask_d = wdata_i[0];
  end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= 1'b0;
    else        mask_q <= mask_d;
  end
  assign gmask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == MASK_ADDR)                rdata_o = {1'b0, mask_q};
    else if (32'(addr_i) < NUM_VEC)         rdata_o = sw_lvl_o[addr_i];
  end
endmodule

// File: rtl/intc_pick.sv
module intc_pick
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC = 26,
  parameter int unsigned IDX_W   = 5
) (
  input  logic [NUM_VEC-1:0]            pend_i,
  input  logic [NUM_VEC-1:0][SW_W-1:0]  sw_lvl_i,
  input  logic                          gmask_i,
  output logic                          win_vld_o,
  output logic [IDX_W-1:0]              win_idx_o,
  output run_lvl_t                      win_lvl_o
);
  run_lvl_t             eff [NUM_VEC];
  logic [NUM_VEC-1:0]   elig;

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_eff
    if (i == RST_VEC) begin : g_rst
      assign eff[i]  = LVL_RESET;
      assign elig[i] = pend_i[i];
    end else if (i == TRAP_VEC) begin : g_trap
      assign eff[i]  = LVL_TRAP;
      assign elig[i] = pend_i[i];
    end else begin : g_mask
      assign eff[i]  = {1'b0, sw_lvl_i[i]};
      assign elig[i] = pend_i[i] && (sw_lvl_i[i] != '0) && !gmask_i;
    end
  end

  // Scan from the top index down so equal levels settle on the lowest index
  always_comb begin
    win_lvl_o = LVL_IDLE;
    win_idx_o = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (elig[i] && (eff[i] >= win_lvl_o)) begin
        win_lvl_o = eff[i];
        win_idx_o = IDX_W'(i);
      end
    end
    win_vld_o = (win_lvl_o != LVL_IDLE);
  end
endmodule

// File: rtl/intc_nest.sv
module intc_nest
  import intc_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     take_i,
  input  logic     take_rst_i,
  input  run_lvl_t take_lvl_i,
  input  logic     ret_i,
  output run_lvl_t cur_lvl_o
);
  localparam int unsigned SP_W = $clog2(DEPTH + 1);

  run_lvl_t          stk_d [DEPTH];
  run_lvl_t          stk_q [DEPTH];
  logic [SP_W-1:0]   sp_d, sp_q;
  run_lvl_t          cur_d, cur_q;
  run_lvl_t          top;

  always_comb begin
    top = LVL_IDLE;
    for (int i = 0; i < DEPTH; i++)
      if (sp_q == SP_W'(i + 1)) top = stk_q[i];
  end

  always_comb begin
    cur_d = cur_q;
    sp_d  = sp_q;
    for (int i = 0; i < DEPTH; i++) stk_d[i] = stk_q[i];
    if (take_i && take_rst_i) begin
      cur_d = LVL_IDLE;
      sp_d  = '0;
    end else if (take_i) begin
      for (int i = 0; i < DEPTH; i++)
        if (sp_q == SP_W'(i)) stk_d[i] = cur_q;
      sp_d  = sp_q + 1'b1;
      cur_d = take_lvl_i;
    end else if (ret_i && (sp_q != '0)) begin
      cur_d = top;
      sp_d  = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= LVL_IDLE;
      sp_q  <= '0;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= LVL_IDLE;
    end else begin
      cur_q <= cur_d;
      sp_q  <= sp_d;
      for (int i = 0; i < DEPTH; i++) stk_q[i] <= stk_d[i];
    end
  end

  assign cur_lvl_o = cur_q;

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !take_rst_i) |-> (32'(sp_q) < DEPTH));

  // R5
  preempt_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !take_rst_i) |=> (cur_q > $past(cur_q)));

  // R7
  ret_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_i && !take_i && (sp_q != '0)) |=> (cur_q < $past(cur_q)));
endmodule

// File: rtl/intc_core.sv
module intc_core
  import intc_pkg::*;
#(
  parameter int unsigned NUM_VEC  = 26,
  parameter int unsigned DEPTH    = 4,
  parameter int unsigned EXT_BASE = 2,
  parameter int unsigned NUM_EXT  = 6,
  parameter int unsigned IDX_W    = $clog2(NUM_VEC + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_VEC-1:0]  req_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_addr_i,
  input  logic [1:0]          cfg_wdata_i,
  output logic [1:0]          cfg_rdata_o,
  output logic                irq_o,
  output logic [IDX_W-1:0]    vec_o,
  input  logic                ack_i,
  input  logic                ret_i,
  output logic [2:0]          cur_lvl_o,
  input  logic                halt_i,
  output logic                wake_o
);
  localparam logic [NUM_VEC-1:0] PEND_RST = NUM_VEC'(1) << RST_VEC;

  logic [NUM_VEC-1:0][SW_W-1:0] sw_lvl;
  logic                         gmask;
  logic [NUM_VEC-1:0]           pend_d, pend_q;
  logic [NUM_VEC-1:0]           clr_vec;
  logic                         win_vld;
  logic [IDX_W-1:0]             win_idx;
  run_lvl_t                     win_lvl;
  run_lvl_t                     cur_lvl;
  logic                         take;

  intc_cfg #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .sw_lvl_o (sw_lvl),
    .gmask_o  (gmask)
  );

  intc_pick #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_pick (
    .pend_i    (pend_q),
    .sw_lvl_i  (sw_lvl),
    .gmask_i   (gmask),
    .win_vld_o (win_vld),
    .win_idx_o (win_idx),
    .win_lvl_o (win_lvl)
  );

  assign irq_o = win_vld && (win_lvl > cur_lvl);
  assign vec_o = win_idx;
  assign take  = ack_i && irq_o;

  intc_nest #(.DEPTH(DEPTH)) u_nest (
    .clk        (clk),
    .rst_n      (rst_n),
    .take_i     (take),
    .take_rst_i (win_idx == IDX_W'(RST_VEC)),
    .take_lvl_i (win_lvl),
    .ret_i      (ret_i),
    .cur_lvl_o  (cur_lvl)
  );
  assign cur_lvl_o = cur_lvl;

  // Pending flags: acceptance clears, a fresh request in the same cycle wins
  for (genvar i = 0; i < NUM_VEC; i++) begin : g_clr
    assign clr_vec[i] = take && (win_idx == IDX_W'(i));
  end

  always_comb pend_d = (pend_q & ~clr_vec) | req_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= PEND_RST;
    else        pend_q <= pend_d;
  end

  // Wake path is purely combinational: no clock runs during halt
  logic [NUM_EXT-1:0] ext_hit;
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    assign ext_hit[e] = req_i[EXT_BASE+e] && (sw_lvl[EXT_BASE+e] != '0);
  end
  assign wake_o = halt_i && (|ext_hit);

  // R3
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req_i[vec_o]) |=> !pend_q[$past(vec_o)]);

  // R10
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gmask && irq_o) |-> (32'(vec_o) < FIXED_VECS));

  // R9
  reset_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (vec_o == IDX_W'(RST_VEC))) |=> (cur_lvl == LVL_IDLE));

  // R6
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && !irq_o && !ret_i) |=> $stable(cur_lvl));
endmodule

// File: tb/test_intc_core.sv
module test_intc_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [25:0] req;
  logic        we;
  logic [4:0]  addr;
  logic [1:0]  wdata;
  logic [1:0]  rdata;
  logic        irq;
  logic [4:0]  vec;
  logic        ack, ret, halt, wake;
  logic [2:0]  cur;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  intc_core i_intc_core (
    .clk(clk), .rst_n(rst_n), .req_i(req),
    .cfg_we_i(we), .cfg_addr_i(addr), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .irq_o(irq), .vec_o(vec), .ack_i(ack), .ret_i(ret),
    .cur_lvl_o(cur), .halt_i(halt), .wake_o(wake)
  );

  // [31:6] request pattern, [5] expected irq, [4:0] expected vector
  localparam logic [31:0] TBL [8] = '{
    {26'h0000004, 1'b1, 5'd2},
    {26'h000000C, 1'b1, 5'd2},
    {26'h0000018, 1'b1, 5'd4},
    {26'h0000060, 1'b1, 5'd5},
    {26'h0100010, 1'b1, 5'd20},
    {26'h0000100, 1'b0, 5'd0},
    {26'h0000022, 1'b1, 5'd1},
    {26'h0000003, 1'b1, 5'd0}
  };

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); we = 1'b1; addr = 5'(a); wdata = 2'(d);
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    @(negedge clk); addr = 5'(a); #1 d = int'(rdata);
  endtask

  task automatic pulse(logic [25:0] m);
    @(negedge clk); req = m;
    @(negedge clk); req = '0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic do_ret();
    @(negedge clk); ret = 1'b1;
    @(negedge clk); ret = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) begin
      if (irq) begin
        automatic logic [4:0] v = vec;
        do_ack();
        if (v != 5'd0) do_ret();
      end
    end
  endtask

  initial begin
    int d;
    rst_n = 1'b0; req = '0; we = 1'b0; addr = '0; wdata = '0;
    ack = 1'b0; ret = 1'b0; halt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 1);
    chk("R1 vec", vec, 0);
    chk("R1 cur", cur, 0);
    rd(5, d);  chk("R1 level", d, 0);
    rd(31, d); chk("R1 mask", d, 0);
    do_ack();
    chk("R9 reset ack level", cur, 0);
    chk("R3 reset pending cleared", irq, 0);

    // R2 configuration
    for (int i = 2; i < 26; i++) wr(i, 1);
    wr(4, 2); wr(5, 3); wr(6, 3); wr(7, 2); wr(8, 0); wr(20, 3);
    rd(4, d);  chk("R2 readback", d, 2);
    rd(8, d);  chk("R2 readback zero", d, 0);
    wr(1, 3);
    rd(1, d);  chk("R2 fixed write ignored", d, 0);

    // R4 arbitration table
    foreach (TBL[t]) begin
      pulse(TBL[t][31:6]);
      chk("R4 table irq", irq, int'(TBL[t][5]));
      if (TBL[t][5]) chk("R4 table vec", vec, int'(TBL[t][4:0]));
      drain();
    end

    // R5 / R6 / R7 equal level waits, higher preempts
    pulse(26'h4); do_ack();
    chk("R6 level after ack", cur, 1);
    pulse(26'h8);
    chk("R5 equal waits", irq, 0);
    pulse(26'h10);
    chk("R5 higher irq", irq, 1);
    chk("R5 higher vec", vec, 4);
    do_ack(); chk("R6 nested level", cur, 2);
    do_ret(); chk("R7 restore", cur, 1);
    chk("R5 still waiting", irq, 0);
    do_ret(); chk("R7 restore idle", cur, 0);
    chk("R3 held request", vec, 3);
    drain();

    // R8 four-deep nesting
    pulse(26'h4);  do_ack();
    pulse(26'h10); do_ack();
    pulse(26'h20); do_ack();
    pulse(26'h2);  do_ack();
    chk("R8 deepest", cur, 4);
    do_ret(); chk("R8 unwind3", cur, 3);
    do_ret(); chk("R8 unwind2", cur, 2);
    do_ret(); chk("R8 unwind1", cur, 1);
    do_ret(); chk("R8 unwind0", cur, 0);
    do_ret(); chk("R7 empty return", cur, 0);

    // R9 reset entry during nesting
    pulse(26'h4);  do_ack();
    pulse(26'h10); do_ack();
    pulse(26'h1);
    chk("R9 reset vec", vec, 0);
    do_ack(); chk("R9 level cleared", cur, 0);
    do_ret(); chk("R9 stack cleared", cur, 0);
    drain();

    // R10 global mask
    wr(31, 1);
    pulse(26'h20);
    chk("R10 masked", irq, 0);
    pulse(26'h2);
    chk("R10 trap passes", vec, 1);
    do_ack(); do_ret();
    chk("R10 still masked", irq, 0);
    wr(31, 0);
    chk("R10 unmasked vec", vec, 5);
    drain();

    // R6 ack with no request
    do_ack(); chk("R6 idle ack ignored", cur, 0);

    // R3 request coincident with acceptance
    pulse(26'h4);
    @(negedge clk); ack = 1'b1; req = 26'h4;
    @(negedge clk); ack = 1'b0; req = '0;
    chk("R3 coincident level", cur, 1);
    do_ret();
    chk("R3 coincident pending", vec, 2);
    drain();

    // R11 wake
    @(negedge clk); halt = 1'b1; req = 26'h4;
    #1 chk("R11 ext wake", wake, 1);
    req = 26'h400;
    #1 chk("R11 non-ext", wake, 0);
    halt = 1'b0; req = 26'h4;
    #1 chk("R11 no halt", wake, 0);
    @(negedge clk); req = '0;
    drain();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule